// File: doc/BRIEF.md
# Block Transfer Address Generator

This block works out the address window for a load or store of several registers in one instruction. From a 32-bit base value, a 16-bit register mask and three mode bits (index before or after, count up or down, write the base back), it produces the lowest and highest word address the transfer touches. It also produces the value the base register would take after the transfer, and strobes that say whether that value is to be written and whether the write targets the program counter. The sequencing of the individual word transfers belongs to a separate unit that consumes these results.

A request is presented with a one-cycle valid strobe. All results are registered and appear, with their own valid strobe, exactly one clock later. Back-to-back requests are accepted on every cycle. When the base register is the program counter, the address window is computed from the base plus 8, while the written-back value always starts from the raw base. All arithmetic wraps modulo 2^32.

Top module: `blkxfer_addr_gen`

## Requirements
- R1: The word count n is the number of ones in `reg_list` (0 to 16), and the byte span is 4·n; for every result, `last_addr - first_addr` equals 4·n − 4 modulo 2^32.
- R2: With `pre_idx`=0 and `up_dir`=0, `first_addr` = B − 4n + 4 and `last_addr` = B, where B is the effective base.
- R3: With `pre_idx`=0 and `up_dir`=1, `first_addr` = B and `last_addr` = B + 4n − 4.
- R4: With `pre_idx`=1 and `up_dir`=0, `first_addr` = B − 4n and `last_addr` = B − 4.
- R5: With `pre_idx`=1 and `up_dir`=1, `first_addr` = B + 4 and `last_addr` = B + 4n.
- R6: The effective base B equals `base_val` + 8 when `base_is_pc`=1 and `base_val` otherwise.
- R7: `wb_value` equals the raw `base_val` + 4n when `up_dir`=1 and `base_val` − 4n when `up_dir`=0, independent of `base_is_pc` and `pre_idx`.
- R8: `wb_en` is 1 in the result cycle exactly when the request had `wb_req`=1; it is 0 in every cycle without a result.
- R9: `pc_upd` is 1 in the result cycle exactly when the request had both `wb_req`=1 and `base_is_pc`=1, and 0 otherwise.
- R10: `out_valid` is 1 exactly one clock after each cycle with `in_valid`=1, with results in request order, and 0 otherwise.
- R11: Address and writeback arithmetic wraps modulo 2^32 in both directions.
- R12: Synchronous active-high reset clears `out_valid`, `first_addr`, `last_addr`, `wb_value`, `wb_en` and `pc_upd` to 0.
- R13: In a cycle after one without a request, `first_addr`, `last_addr` and `wb_value` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| base_is_pc | input | 1 | Base register is the program counter |
| pre_idx | input | 1 | 1: index before each transfer, 0: after |
| up_dir | input | 1 | 1: addresses ascend, 0: descend |
| wb_req | input | 1 | Base writeback requested |
| reg_list | input | 16 | Register mask, one bit per register |
| out_valid | output | 1 | Result strobe |
| first_addr | output | 32 | Lowest word address of the transfer |
| last_addr | output | 32 | Highest word address of the transfer |
| wb_value | output | 32 | New base register value |
| wb_en | output | 1 | Writeback enable |
| pc_upd | output | 1 | Writeback targets the program counter |

## Verification
The assertions check on every cycle the one-clock result latency, the span relation between the two addresses, the writeback value against the raw base and the direction bit, the gating of the two strobes, the plus-8 correction in the ascending-after mode, and that addresses hold between requests. Only the bench scenarios show that each of the four modes places its window correctly for empty, full and sparse masks, that wrap-around near zero and near the top of the address space comes out right, and that back-to-back requests keep their order.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

    localparam int ADDR_W     = 32;
    localparam int LIST_W     = 16;
    localparam int CNT_W      = $clog2(LIST_W + 1);
    localparam int WORD_BYTES = 4;
    localparam int PC_AHEAD   = 8;

    typedef enum logic [1:0] {
        MODE_DEC_AFTER  = 2'b00,
        MODE_INC_AFTER  = 2'b01,
        MODE_DEC_BEFORE = 2'b10,
        MODE_INC_BEFORE = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              base_pc;
        logic              pre;
        logic              up;
        logic              wb;
        logic [LIST_W-1:0] list;
    } xfer_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] wb_val;
        logic              wb_en;
        logic              pc_chg;
    } xfer_res_t;

    function automatic xfer_mode_e mode_of(input logic pre, input logic up);
        return xfer_mode_e'({pre, up});
    endfunction

    function automatic logic [ADDR_W-1:0] span_of(input logic [CNT_W-1:0] n);
        return ADDR_W'(n) * ADDR_W'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/blkx_popcount.sv
module blkx_popcount #(
    parameter int W  = blkx_pkg::LIST_W,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] partial [W+1];

    assign partial[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_acc
        assign partial[i+1] = partial[i] + CW'(bits_i[i]);
    end

    assign count_o = partial[W];
endmodule

// File: rtl/blkx_addr_calc.sv
module blkx_addr_calc
    import blkx_pkg::*;
(
    input  xfer_req_t        req_i,
    input  logic [CNT_W-1:0] count_i,
    output xfer_res_t        res_o
);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(PC_AHEAD);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] eff_base;
    xfer_mode_e        mode;

    always_comb begin
        span     = span_of(count_i);
        eff_base = req_i.base_pc ? (req_i.base + AHEAD) : req_i.base;
        mode     = mode_of(req_i.pre, req_i.up);
        res_o    = '0;

        unique case (mode)
            MODE_DEC_AFTER: begin
                res_o.first = eff_base - span + STEP;
                res_o.last  = eff_base;
            end
            MODE_INC_AFTER: begin
                res_o.first = eff_base;
                res_o.last  = eff_base + span - STEP;
            end
            MODE_DEC_BEFORE: begin
                res_o.first = eff_base - span;
                res_o.last  = eff_base - STEP;
            end
            MODE_INC_BEFORE: begin
                res_o.first = eff_base + STEP;
                res_o.last  = eff_base + span;
            end
            default: begin
                res_o.first = eff_base;
                res_o.last  = eff_base;
            end
        endcase

        res_o.wb_val = req_i.up ? (req_i.base + span) : (req_i.base - span);
        res_o.wb_en  = req_i.wb;
        res_o.pc_chg = req_i.wb & req_i.base_pc;
    end
endmodule

// File: rtl/blkx_out_reg.sv
module blkx_out_reg
    import blkx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid_i,
    input  xfer_res_t res_i,
    output logic      valid_o,
    output xfer_res_t res_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            res_o   <= '0;
        end else begin
            valid_o      <= valid_i;
            res_o.wb_en  <= valid_i & res_i.wb_en;
            res_o.pc_chg <= valid_i & res_i.pc_chg;
            if (valid_i) begin
                res_o.first  <= res_i.first;
                res_o.last   <= res_i.last;
                res_o.wb_val <= res_i.wb_val;
            end
        end
    end
endmodule

// File: rtl/blkxfer_addr_gen.sv
module blkxfer_addr_gen
    import blkx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              base_is_pc,
    input  logic              pre_idx,
    input  logic              up_dir,
    input  logic              wb_req,
    input  logic [LIST_W-1:0] reg_list,
    output logic              out_valid,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] wb_value,
    output logic              wb_en,
    output logic              pc_upd
);
    xfer_req_t        req;
    xfer_res_t        res_d;
    xfer_res_t        res_q;
    logic [CNT_W-1:0] word_cnt;

    assign req.base    = base_val;
    assign req.base_pc = base_is_pc;
    assign req.pre     = pre_idx;
    assign req.up      = up_dir;
    assign req.wb      = wb_req;
    assign req.list    = reg_list;

    blkx_popcount #(.W(LIST_W), .CW(CNT_W)) u_count (
        .bits_i  (req.list),
        .count_o (word_cnt)
    );

    blkx_addr_calc u_calc (
        .req_i   (req),
        .count_i (word_cnt),
        .res_o   (res_d)
    );

    blkx_out_reg u_oreg (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid),
        .res_i   (res_d),
        .valid_o (out_valid),
        .res_o   (res_q)
    );

    assign first_addr = res_q.first;
    assign last_addr  = res_q.last;
    assign wb_value   = res_q.wb_val;
    assign wb_en      = res_q.wb_en;
    assign pc_upd     = res_q.pc_chg;
endmodule

// File: rtl/blkx_chk.sv
module blkx_chk #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [AW-1:0] base_val,
    input logic          base_is_pc,
    input logic          pre_idx,
    input logic          up_dir,
    input logic          wb_req,
    input logic [LW-1:0] reg_list,
    input logic          out_valid,
    input logic [AW-1:0] first_addr,
    input logic [AW-1:0] last_addr,
    input logic [AW-1:0] wb_value,
    input logic          wb_en,
    input logic          pc_upd
);
    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    p_span_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((last_addr - first_addr) ==
                       (AW'($countones($past(reg_list))) * AW'(4) - AW'(4))));

    p_wbval_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (wb_value == ($past(up_dir)
            ? ($past(base_val) + AW'($countones($past(reg_list))) * AW'(4))
            : ($past(base_val) - AW'($countones($past(reg_list))) * AW'(4)))));

    p_wben_r8: assert property (@(posedge clk) disable iff (rst)
        wb_en == (out_valid && $past(wb_req)));

    p_pcupd_r9: assert property (@(posedge clk) disable iff (rst)
        pc_upd == (out_valid && $past(wb_req) && $past(base_is_pc)));

    p_pcbase_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(pre_idx) && $past(up_dir)) |->
            (first_addr == ($past(base_is_pc) ? $past(base_val) + AW'(8)
                                              : $past(base_val))));

    p_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(first_addr) && $stable(last_addr) && $stable(wb_value)));
endmodule

bind blkxfer_addr_gen blkx_chk #(.AW(blkx_pkg::ADDR_W), .LW(blkx_pkg::LIST_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .base_val   (base_val),
    .base_is_pc (base_is_pc),
    .pre_idx    (pre_idx),
    .up_dir     (up_dir),
    .wb_req     (wb_req),
    .reg_list   (reg_list),
    .out_valid  (out_valid),
    .first_addr (first_addr),
    .last_addr  (last_addr),
    .wb_value   (wb_value),
    .wb_en      (wb_en),
    .pc_upd     (pc_upd)
);

// File: tb/blkxfer_addr_gen_tb_top.sv
module blkxfer_addr_gen_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic        base_is_pc = 1'b0;
    logic        pre_idx = 1'b0;
    logic        up_dir = 1'b0;
    logic        wb_req = 1'b0;
    logic [15:0] reg_list = '0;
    logic        out_valid;
    logic [31:0] first_addr;
    logic [31:0] last_addr;
    logic [31:0] wb_value;
    logic        wb_en;
    logic        pc_upd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] first;
        logic [31:0] last;
        logic [31:0] wbv;
        logic        we;
        logic        pcu;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t last_exp;

    always #2.5 clk = ~clk;

    blkxfer_addr_gen dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .base_val(base_val),
        .base_is_pc(base_is_pc), .pre_idx(pre_idx), .up_dir(up_dir),
        .wb_req(wb_req), .reg_list(reg_list), .out_valid(out_valid),
        .first_addr(first_addr), .last_addr(last_addr), .wb_value(wb_value),
        .wb_en(wb_en), .pc_upd(pc_upd)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] b, input logic pc, input logic p,
                                   input logic u, input logic w, input logic [15:0] l,
                                   input string tag);
        exp_t e;
        int n = 0;
        logic [31:0] span, eb;
        for (int i = 0; i < 16; i++) n += int'(l[i]);
        span = 32'(n) * 32'd4;
        eb = pc ? b + 32'd8 : b;
        case ({p, u})
            2'b00: begin e.first = eb - span + 32'd4; e.last = eb; end
            2'b01: begin e.first = eb; e.last = eb + span - 32'd4; end
            2'b10: begin e.first = eb - span; e.last = eb - 32'd4; end
            default: begin e.first = eb + 32'd4; e.last = eb + span; end
        endcase
        e.wbv = u ? b + span : b - span;
        e.we  = w;
        e.pcu = w & pc;
        e.tag = tag;
        return e;
    endfunction

    // Driver: called just after a falling edge; holds the request for one cycle.
    task automatic send(input logic [31:0] b, input logic pc, input logic p,
                        input logic u, input logic w, input logic [15:0] l,
                        input string tag);
        exp_t e;
        e = model(b, pc, p, u, w, l, tag);
        sb_q.push_back(e);
        last_exp = e;
        in_valid = 1'b1; base_val = b; base_is_pc = pc;
        pre_idx = p; up_dir = u; wb_req = w; reg_list = l;
        @(negedge clk);
    endtask

    task automatic idle(input int cycles);
        in_valid = 1'b0;
        base_val = 32'hDEAD_BEEF; reg_list = 16'hA5A5; wb_req = 1'b1; base_is_pc = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    // Monitor: compares results against the scoreboard on each falling edge.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R10 unexpected out_valid: actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "first_addr", first_addr, e.first);
                chk(e.tag, "last_addr", last_addr, e.last);
                chk("R7", "wb_value", wb_value, e.wbv);
                chk("R8", "wb_en", 32'(wb_en), 32'(e.we));
                chk("R9", "pc_upd", 32'(pc_upd), 32'(e.pcu));
            end
        end else if (!rst) begin
            chk("R8", "wb_en idle", 32'(wb_en), 32'd0);
            chk("R9", "pc_upd idle", 32'(pc_upd), 32'd0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "out_valid", 32'(out_valid), 32'd0);
        chk("R12", "first_addr", first_addr, 32'd0);
        chk("R12", "last_addr", last_addr, 32'd0);
        chk("R12", "wb_value", wb_value, 32'd0);
        chk("R12", "wb_en", 32'(wb_en), 32'd0);
        chk("R12", "pc_upd", 32'(pc_upd), 32'd0);
        rst = 1'b0;
        idle(2);

        // R2..R5: each mode with a sparse mask
        send(32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00F0, "R2");
        send(32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0303, "R3");
        send(32'h0000_2000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h8001, "R4");
        send(32'h0000_2000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h1111, "R5");
        idle(1);
        // R1: full mask and empty mask
        send(32'h4000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R1");
        send(32'h4000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF, "R1");
        send(32'h4000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, "R1");
        send(32'h4000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, "R1");
        idle(2);
        // R6 / R9: program-counter base, with and without writeback
        send(32'h0000_8000, 1'b1, 1'b0, 1'b1, 1'b1, 16'h000F, "R6");
        send(32'h0000_8000, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0007, "R6");
        send(32'h0000_8000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0003, "R6");
        send(32'h0000_8000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h00FF, "R9");
        idle(1);
        // R11: wrap near zero and near the top
        send(32'h0000_0008, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00FF, "R11");
        send(32'h0000_0004, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF, "R11");
        send(32'hFFFF_FFF8, 1'b0, 1'b1, 1'b1, 1'b1, 16'h000F, "R11");
        send(32'hFFFF_FFF4, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0F00, "R11");
        // R8: no writeback request
        send(32'h1234_5670, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0101, "R8");
        idle(4);

        // R10: every result arrived, none left pending
        chk("R10", "pending results", 32'(sb_q.size()), 32'd0);
        // R13: addresses hold while idle inputs change
        chk("R13", "first_addr held", first_addr, last_exp.first);
        chk("R13", "last_addr held", last_addr, last_exp.last);
        chk("R13", "wb_value held", wb_value, last_exp.wbv);
        chk("R10", "out_valid idle", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule